// File: doc/BRIEF.md
# Synchronized Three-Phase PWM Timebase

This block generates three center-aligned PWM legs for a three-phase bridge. Each leg owns a triangle carrier: a counter that climbs from zero to the period value and falls back to zero, so one carrier cycle lasts twice the period value in clocks. A leg's output is high while its counter is below its compare value. The default period of 6250 gives a 50 µs carrier at 250 MHz.

Leg 0 is the master. Legs 1 and 2 are slaves that follow the master's timing. Whenever the master counter reaches zero, each slave jumps to its own programmable phase value and counts upward from there. This lets software shift the slave carriers against the master, or keep all three aligned with the default phase of 0.

Period and compare values are written into shadow registers. A shadow value reaches the active register only when that leg's counter arrives at zero. A new value therefore never changes a carrier cycle that is already running. The block drives one raw PWM level per leg, a counter-zero flag per leg and a sync pulse. Dead-time insertion and fault shutdown belong to downstream logic.

Top module: `pwm3_timebase`

## Requirements
- R1: While reset is asserted, every counter is 0 and counting up, every period is 6250 (active and shadow), every compare value and phase value is 0, `pwm_o` is 000, `zero_o` is 111 and `sync_o` is 1.
- R2: Each counter counts up by one per clock until it reaches the active period, then counts down by one per clock until it reaches 0, then counts up again. With period P, a free-running leg therefore passes through 0 once every 2·P clocks, and `zero_o[i]` is high exactly in the cycles in which counter i equals 0.
- R3: `pwm_o[i]` is high in a cycle exactly when counter i is strictly below the active compare value of leg i. An exception is made by R4. A compare value of 0 keeps the leg low for the whole carrier cycle.
- R4: When the active compare value is greater than or equal to the active period, `pwm_o[i]` is high for the whole carrier cycle.
- R5: A compare value written with `cmp_wr[i]` goes into a shadow register. It becomes active starting with the next cycle in which counter i equals 0, and never while counter i is nonzero.
- R6: A period written with `prd_wr` goes into the shadow register of every leg. Each leg uses the new period starting with the next cycle in which its own counter equals 0, and never while that counter is nonzero.
- R7: `sync_o` is high exactly in the cycles in which the master counter (leg 0) equals 0.
- R8: In every cycle in which the master counter equals 0, each slave counter (legs 1 and 2) equals the phase value it held before that clock edge. From there the slave counts up and then follows R2.
- R9: Writing a phase value to leg 0 with `phs_wr[0]` has no effect. The master keeps its phase disabled and never reloads from a phase register.
- R10: With slave phase values of 0, the three counters stay equal once they have passed a common zero. All `zero_o` bits then rise together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prd_wr | input | 1 | Write `prd_data` into the period shadow of all legs |
| prd_data | input | CNT_W | Period value |
| cmp_wr | input | NUM_SLAVES+1 | Per-leg write strobe for the compare shadow |
| cmp_data | input | CNT_W | Compare value |
| phs_wr | input | NUM_SLAVES+1 | Per-leg write strobe for the phase register (ignored on leg 0) |
| phs_data | input | CNT_W | Phase value |
| pwm_o | output | NUM_SLAVES+1 | Raw PWM level per leg |
| zero_o | output | NUM_SLAVES+1 | Per-leg flag, high while that counter equals 0 |
| sync_o | output | 1 | Sync pulse, high while the master counter equals 0 |

## Verification
The bench writes compare values in the middle of a carrier cycle and shortens the period in the middle of a cycle. A design that loaded its shadow registers immediately would produce a shortened or glitched pulse in that same cycle. It sets compare values of 0 and of the period value itself. A design that gets these extremes wrong would produce a one-clock sliver of high or low at the carrier peak or valley. It gives the slaves nonzero phase values and also writes a phase value to the master. A design that reloaded the master, or that loaded the slaves one clock late, would make the pattern of the zero flags drift away from the expected offsets. Finally it restores a phase of 0 and checks that all three zero flags rise in the same cycle.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    // Direction of a triangle carrier counter.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

endpackage

// File: rtl/pwm3_leg.sv
module pwm3_leg
    import pwm3_pkg::*;
#(
    parameter int unsigned W        = 16,
    parameter int unsigned PRD_RST  = 6250,
    parameter bit          PHASE_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         prd_wr,
    input  logic [W-1:0] prd_data,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_data,
    input  logic         phs_wr,
    input  logic [W-1:0] phs_data,
    input  logic         sync_in,
    output logic         sync_out,
    output logic         pwm_o,
    output logic         zero_o,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] prd_o,
    output logic [W-1:0] cmp_o,
    output logic [W-1:0] phs_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        cnt_dir_e     dir;
        logic [W-1:0] prd_a;
        logic [W-1:0] prd_s;
        logic [W-1:0] cmp_a;
        logic [W-1:0] cmp_s;
        logic [W-1:0] phs;
        logic         pwm;
        logic         zero;
    } leg_st_t;

    leg_st_t      s_d, s_q;
    logic [W-1:0] nxt_cnt;
    logic         nat_zero;

    always_comb begin
        s_d = s_q;

        // Free-running triangle step.
        nxt_cnt = s_q.cnt;
        if (s_q.dir == DIR_UP) begin
            if (s_q.cnt >= s_q.prd_a) begin
                s_d.dir = DIR_DOWN;
                nxt_cnt = (s_q.cnt == '0) ? '0 : s_q.cnt - 1'b1;
            end else begin
                nxt_cnt = s_q.cnt + 1'b1;
            end
        end else begin
            if (s_q.cnt == '0) begin
                s_d.dir = DIR_UP;
                nxt_cnt = (s_q.prd_a == '0) ? '0 : W'(1);
            end else begin
                nxt_cnt = s_q.cnt - 1'b1;
            end
        end
        nat_zero = (nxt_cnt == '0);

        // Sync: master originates the pulse one cycle early, slaves relay it
        // and reload from their phase register.
        if (PHASE_EN) begin
            sync_out = sync_in;
            if (sync_in) begin
                nxt_cnt = s_q.phs;
                s_d.dir = DIR_UP;
            end
        end else begin
            sync_out = nat_zero;
        end
        s_d.cnt = nxt_cnt;

        // Shadow transfer when the counter arrives at zero (old shadow value).
        if (nxt_cnt == '0) begin
            s_d.prd_a = s_q.prd_s;
            s_d.cmp_a = s_q.cmp_s;
        end

        // Register writes land in the shadows.
        if (prd_wr) s_d.prd_s = prd_data;
        if (cmp_wr) s_d.cmp_s = cmp_data;
        if (PHASE_EN && phs_wr) s_d.phs = phs_data;

        s_d.pwm  = (s_d.cmp_a >= s_d.prd_a) || (nxt_cnt < s_d.cmp_a);
        s_d.zero = (nxt_cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt   <= '0;
            s_q.dir   <= DIR_UP;
            s_q.prd_a <= W'(PRD_RST);
            s_q.prd_s <= W'(PRD_RST);
            s_q.cmp_a <= '0;
            s_q.cmp_s <= '0;
            s_q.phs   <= '0;
            s_q.pwm   <= 1'b0;
            s_q.zero  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign pwm_o  = s_q.pwm;
    assign zero_o = s_q.zero;
    assign cnt_o  = s_q.cnt;
    assign prd_o  = s_q.prd_a;
    assign cmp_o  = s_q.cmp_a;
    assign phs_o  = s_q.phs;

endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase #(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned NUM_SLAVES = 2,
    parameter int unsigned PRD_RST    = 6250
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  prd_wr,
    input  logic [CNT_W-1:0]      prd_data,
    input  logic [NUM_SLAVES:0]   cmp_wr,
    input  logic [CNT_W-1:0]      cmp_data,
    input  logic [NUM_SLAVES:0]   phs_wr,
    input  logic [CNT_W-1:0]      phs_data,
    output logic [NUM_SLAVES:0]   pwm_o,
    output logic [NUM_SLAVES:0]   zero_o,
    output logic                  sync_o
);

    localparam int unsigned NLEG = NUM_SLAVES + 1;

    logic [NLEG:0]                 sync_w;
    logic [NLEG-1:0][CNT_W-1:0]    cnt_w, prd_w, cmp_w, phs_w;
    logic                          sync_d, sync_q;

    assign sync_w[0] = 1'b0;

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        pwm3_leg #(
            .W        (CNT_W),
            .PRD_RST  (PRD_RST),
            .PHASE_EN (g != 0)
        ) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .prd_wr   (prd_wr),
            .prd_data (prd_data),
            .cmp_wr   (cmp_wr[g]),
            .cmp_data (cmp_data),
            .phs_wr   (phs_wr[g]),
            .phs_data (phs_data),
            .sync_in  (sync_w[g]),
            .sync_out (sync_w[g+1]),
            .pwm_o    (pwm_o[g]),
            .zero_o   (zero_o[g]),
            .cnt_o    (cnt_w[g]),
            .prd_o    (prd_w[g]),
            .cmp_o    (cmp_w[g]),
            .phs_o    (phs_w[g])
        );
    end

    always_comb begin
        sync_d = sync_w[NLEG];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b1;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/pwm3_timebase_chk.sv
module pwm3_timebase_chk #(
    parameter int unsigned W  = 16,
    parameter int unsigned NL = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sync_o,
    input logic [NL-1:0]        pwm_o,
    input logic [NL-1:0][W-1:0] cnt,
    input logic [NL-1:0][W-1:0] prd,
    input logic [NL-1:0][W-1:0] cmp,
    input logic [NL-1:0][W-1:0] phs
);

    assert_master_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[0] <= prd[0]);

    assert_master_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[0] == W'($past(cnt[0]) + 1'b1)) || (cnt[0] == W'($past(cnt[0]) - 1'b1)) ||
        ((cnt[0] == '0) && ($past(cnt[0]) == '0)));

    assert_cmp_zero_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp[0] == '0 && prd[0] != '0) |-> !pwm_o[0]);

    assert_cmp_full_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp[1] >= prd[1]) |-> pwm_o[1]);

    assert_cmp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[0] != '0) |-> $stable(cmp[0]));

    assert_prd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[2] != '0) |-> $stable(prd[2]));

    assert_sync_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> (cnt[0] == '0));

    assert_slave_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> (cnt[1] == $past(phs[1])));

endmodule

bind pwm3_timebase pwm3_timebase_chk #(
    .W  (CNT_W),
    .NL (NUM_SLAVES + 1)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_o (sync_o),
    .pwm_o  (pwm_o),
    .cnt    (cnt_w),
    .prd    (prd_w),
    .cmp    (cmp_w),
    .phs    (phs_w)
);

// File: tb/test_pwm3_timebase.sv
module test_pwm3_timebase;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         prd_wr = 1'b0;
    logic [W-1:0] prd_data = '0;
    logic [2:0]   cmp_wr = '0;
    logic [W-1:0] cmp_data = '0;
    logic [2:0]   phs_wr = '0;
    logic [W-1:0] phs_data = '0;
    logic [2:0]   pwm_o, zero_o;
    logic         sync_o;

    always #2 clk = ~clk;  // 250 MHz

    pwm3_timebase i_pwm3_timebase (
        .clk(clk), .rst_n(rst_n),
        .prd_wr(prd_wr), .prd_data(prd_data),
        .cmp_wr(cmp_wr), .cmp_data(cmp_data),
        .phs_wr(phs_wr), .phs_data(phs_data),
        .pwm_o(pwm_o), .zero_o(zero_o), .sync_o(sync_o)
    );

    typedef struct { logic [2:0] pwm; logic [2:0] zero; logic sync; } exp_t;
    exp_t exp_q[$];

    int    n_cmp = 0, n_bad = 0, cyc = 0;
    string cur_tag = "R1";

    // Reference model, built from the requirements.
    logic [W-1:0] m_cnt[3], m_prd_a[3], m_prd_s[3], m_cmp_a[3], m_cmp_s[3], m_phs[3];
    bit           m_down[3];

    always @(posedge clk) begin
        exp_t         e;
        logic [W-1:0] nx[3];
        bit           msync;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_cnt[i] = '0; m_down[i] = 1'b0; m_prd_a[i] = 16'd6250; m_prd_s[i] = 16'd6250;
                m_cmp_a[i] = '0; m_cmp_s[i] = '0; m_phs[i] = '0;
            end
            e.pwm = 3'b000; e.zero = 3'b111; e.sync = 1'b1;
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (!m_down[i]) begin
                    if (m_cnt[i] >= m_prd_a[i]) begin
                        m_down[i] = 1'b1;
                        nx[i] = (m_cnt[i] == 0) ? 16'd0 : m_cnt[i] - 16'd1;
                    end else nx[i] = m_cnt[i] + 16'd1;
                end else begin
                    if (m_cnt[i] == 0) begin
                        m_down[i] = 1'b0;
                        nx[i] = (m_prd_a[i] == 0) ? 16'd0 : 16'd1;
                    end else nx[i] = m_cnt[i] - 16'd1;
                end
            end
            msync = (nx[0] == 0);
            for (int i = 1; i < 3; i++)
                if (msync) begin nx[i] = m_phs[i]; m_down[i] = 1'b0; end
            for (int i = 0; i < 3; i++) begin
                if (nx[i] == 0) begin m_prd_a[i] = m_prd_s[i]; m_cmp_a[i] = m_cmp_s[i]; end
                m_cnt[i]  = nx[i];
                e.pwm[i]  = (m_cmp_a[i] >= m_prd_a[i]) || (m_cnt[i] < m_cmp_a[i]);
                e.zero[i] = (m_cnt[i] == 0);
                if (prd_wr)    m_prd_s[i] = prd_data;
                if (cmp_wr[i]) m_cmp_s[i] = cmp_data;
                if (phs_wr[i] && i != 0) m_phs[i] = phs_data;
            end
            e.sync = msync;
        end
        exp_q.push_back(e);
    end

    // Monitor: pops expectations and compares away from the active edge.
    always @(negedge clk) begin
        exp_t e;
        cyc++;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_cmp++;
            if (pwm_o !== e.pwm || zero_o !== e.zero || sync_o !== e.sync) begin
                n_bad++;
                $display("FAIL %s cyc %0d: pwm %b zero %b sync %b, expected pwm %b zero %b sync %b",
                         cur_tag, cyc, pwm_o, zero_o, sync_o, e.pwm, e.zero, e.sync);
            end
        end
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] expv);
        n_cmp++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, expv);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_prd(input logic [W-1:0] v);
        prd_data = v; prd_wr = 1'b1; @(negedge clk); prd_wr = 1'b0;
    endtask

    task automatic wr_cmp(input logic [2:0] m, input logic [W-1:0] v);
        cmp_data = v; cmp_wr = m; @(negedge clk); cmp_wr = '0;
    endtask

    task automatic wr_phs(input logic [2:0] m, input logic [W-1:0] v);
        phs_data = v; phs_wr = m; @(negedge clk); phs_wr = '0;
    endtask

    task automatic wait_master_zero();
        while (zero_o[0] !== 1'b1) @(negedge clk);
    endtask

    initial begin
        run(3);
        // R1: reset outputs
        chk("R1 pwm", {29'd0, pwm_o}, 32'd0);
        chk("R1 zero", {29'd0, zero_o}, 32'd7);
        chk("R1 sync", {31'd0, sync_o}, 32'd1);
        rst_n = 1'b1;

        // R6: period shadow, applied at the next zero of the default carrier
        cur_tag = "R6 R2 R7 R10";
        wr_prd(16'd10);
        wr_cmp(3'b111, 16'd4);
        run(12600);
        // R2: master zero spacing equals twice the period
        @(negedge clk); wait_master_zero();
        @(negedge clk);
        begin
            int gap = 1;
            while (zero_o[0] !== 1'b1) begin @(negedge clk); gap++; end
            chk("R2 spacing", gap, 20);
        end
        // R10: phase 0 keeps all legs aligned
        chk("R10 aligned zero", {29'd0, zero_o}, 32'd7);

        // R3 / R4: compare extremes
        cur_tag = "R3 R4 R5";
        run(7);
        wr_cmp(3'b001, 16'd0);
        wr_cmp(3'b010, 16'd10);
        wr_cmp(3'b100, 16'd15);
        run(60);
        wait_master_zero(); @(negedge clk);
        chk("R3 cmp0 low", {31'd0, pwm_o[0]}, 32'd0);
        chk("R4 cmp=prd high", {31'd0, pwm_o[1]}, 32'd1);
        chk("R4 cmp>prd high", {31'd0, pwm_o[2]}, 32'd1);

        // R5: mid-period compare change
        run(5);
        wr_cmp(3'b111, 16'd7);
        run(60);

        // R8 / R9: slave phase offsets, master phase write ignored
        cur_tag = "R8 R9";
        wr_phs(3'b010, 16'd3);
        wr_phs(3'b100, 16'd8);
        wr_phs(3'b001, 16'd6);
        run(80);
        wait_master_zero();
        chk("R7 sync at master zero", {31'd0, sync_o}, 32'd1);
        chk("R9 master zero only", {29'd0, zero_o}, 32'd1);
        run(1);

        // R6: period shortened mid-period
        cur_tag = "R6 R2";
        run(4);
        wr_prd(16'd6);
        wr_cmp(3'b111, 16'd2);
        run(80);

        // R10: restore zero phase, legs realign
        cur_tag = "R10 R8";
        wr_phs(3'b110, 16'd0);
        run(40);
        wait_master_zero();
        chk("R10 realigned zero", {29'd0, zero_o}, 32'd7);
        run(30);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule